// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Commit

This block keeps the wall-clock time of day and the date. A one-cycle pulse, `sec_tick`, arrives once per second from the slow timekeeping domain, and each pulse advances the seconds field. Carries ripple into minutes and hours. At midnight the date advances.

The date is kept in one of two forms. In calendar form the date word holds a day, a month and a year. The year is an offset from 1970, and a leap-year bit supplied by software selects 29 or 28 days for February. In linear form the date word is a plain 16-bit day count.

Software does not write the counters directly. A bus write to the time or the date is captured into a holding register and raises a busy bit in the status word. The value is committed into the counter on the second tick after the write, and the busy bit then clears. Software polls the busy bits (status bits 9 to 7) before it writes again.

Top module: `wc_calendar`

## Requirements
- R1: After reset, `time_o` reads 0 (00:00:00), `date_o` reads 32'h0000_0101 (day 1, month 1, year offset 0, leap bit clear), and `status_o` reads 0.
- R2: Each cycle with `sec_tick` high advances the seconds field (`time_o[5:0]`) by one. With no tick and no pending commit, neither `time_o` nor `date_o` changes.
- R3: The seconds field wraps from 59 to 0 and carries into minutes (`time_o[13:8]`). Minutes wrap from 59 to 0 and carry into hours (`time_o[20:16]`). Hours wrap from 23 to 0, and that wrap advances the date on the same tick.
- R4: In calendar form (`lin_mode`=0) the date word holds day in bits 4:0, month 1 to 12 in bits 11:8, year offset 0 to 63 in bits 21:16 and the leap bit in bit 22. The day wraps to 1 after 31, 30 or 28 days by month, or after 29 for February when bit 22 is set. The month wraps from 12 to 1 and advances the year. Year 63 wraps to 0. Bit 22 is held as written.
- R5: In linear form (`lin_mode`=1) a date advance increments `date_o[15:0]`, wraps from 65535 to 0, and leaves bits 31:16 at 0.
- R6: A cycle with `wr_time` high while status bit 8 is clear sets status bit 8 from the next cycle. The written value appears on `time_o` after the second `sec_tick` that follows the write, in place of that tick's advance, and status bit 8 clears at the same moment.
- R7: `wr_date` behaves the same way for the date word, using status bit 7.
- R8: A write to the time or the date while its busy bit is set is ignored. The value committed is the first write's value.
- R9: Status bit 9 (the alarm busy position) and every other status bit apart from bits 8 and 7 always read 0.
- R10: A committed value keeps only its defined field bits. The time mask is 32'h001F_3F3F. The date mask is 32'h007F_0F1F in calendar form and 32'h0000_FFFF in linear form, chosen by `lin_mode` at the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| lin_mode | input | 1 | 1 selects linear day count, 0 selects calendar form |
| wr_time | input | 1 | Write strobe for the time word |
| wr_date | input | 1 | Write strobe for the date word |
| wr_data | input | 32 | Write data shared by both strobes |
| time_o | output | 32 | Current time of day (hours, minutes, seconds) |
| date_o | output | 32 | Current date word |
| status_o | output | 32 | Busy flags: bit 8 time, bit 7 date, bit 9 reads 0 |

## Verification
The checker checks some rules on every cycle:
- A write raises its busy bit on the next cycle.
- A busy bit drops only on a tick.
- The time word stays put without a tick while no time commit is pending.
- Seconds step by one, or wrap from 59, on an undisturbed tick.
- The unused time bits stay clear.

Month lengths, the leap-bit choice, the year wrap, the linear wrap and the ignored second write depend on particular values being reached. Only the bench scenarios show these behaviours. The bench compares every cycle against a behavioural model fed through a scoreboard queue.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int WORD_W = 32;
    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int MONTH_LAST = 12;
    localparam int DAY_W = 16;

    localparam logic [WORD_W-1:0] TIME_MASK  = 32'h001F_3F3F;
    localparam logic [WORD_W-1:0] CAL_MASK   = 32'h007F_0F1F;
    localparam logic [WORD_W-1:0] LIN_MASK   = 32'h0000_FFFF;
    localparam logic [WORD_W-1:0] DATE_RESET = 32'h0000_0101;

    // days in a month, leap flag chooses February length
    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        logic [4:0] len;
        case (mon)
            4'd2:                     len = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  len = 5'd30;
            default:                  len = 5'd31;
        endcase
        return len;
    endfunction
endpackage

// File: rtl/wc_time_step.sv
module wc_time_step
    import wc_pkg::*;
(
    input  logic [WORD_W-1:0] t_i,
    output logic [WORD_W-1:0] t_o,
    output logic              day_wrap_o
);
    logic [5:0] sc_d, mn_d;
    logic [4:0] hr_d;

    always_comb begin
        sc_d = t_i[5:0];
        mn_d = t_i[13:8];
        hr_d = t_i[20:16];
        day_wrap_o = 1'b0;
        if (int'(sc_d) >= SEC_LAST) begin
            sc_d = '0;
            if (int'(mn_d) >= MIN_LAST) begin
                mn_d = '0;
                if (int'(hr_d) >= HOUR_LAST) begin
                    hr_d = '0;
                    day_wrap_o = 1'b1;
                end else begin
                    hr_d = hr_d + 5'd1;
                end
            end else begin
                mn_d = mn_d + 6'd1;
            end
        end else begin
            sc_d = sc_d + 6'd1;
        end
        t_o = {11'b0, hr_d, 2'b0, mn_d, 2'b0, sc_d};
    end
endmodule

// File: rtl/wc_date_step.sv
module wc_date_step
    import wc_pkg::*;
#(
    parameter int YEAR_LAST = 63
) (
    input  logic [WORD_W-1:0] d_i,
    input  logic              lin_i,
    output logic [WORD_W-1:0] d_o
);
    logic [4:0] day_d;
    logic [3:0] mon_d;
    logic [5:0] yr_d;
    logic       leap;
    logic [DAY_W-1:0] cnt_d;

    always_comb begin
        day_d = d_i[4:0];
        mon_d = d_i[11:8];
        yr_d  = d_i[21:16];
        leap  = d_i[22];
        cnt_d = d_i[DAY_W-1:0] + DAY_W'(1);
        if (day_d >= month_len(mon_d, leap)) begin
            day_d = 5'd1;
            if (int'(mon_d) >= MONTH_LAST) begin
                mon_d = 4'd1;
                if (int'(yr_d) >= YEAR_LAST) yr_d = '0;
                else                         yr_d = yr_d + 6'd1;
            end else begin
                mon_d = mon_d + 4'd1;
            end
        end else begin
            day_d = day_d + 5'd1;
        end
        if (lin_i) d_o = {{(WORD_W-DAY_W){1'b0}}, cnt_d};
        else       d_o = {9'b0, leap, yr_d, 4'b0, mon_d, 3'b0, day_d};
    end
endmodule

// File: rtl/wc_commit.sv
module wc_commit #(
    parameter int W     = 32,
    parameter int TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         busy_o,
    output logic         fire_o,
    output logic [W-1:0] val_o
);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  val;
    } cm_t;

    cm_t s_d, s_q;
    logic fire;

    always_comb begin
        fire = s_q.busy && tick && (s_q.cnt == CW'(TICKS - 1));
        s_d  = s_q;
        if (fire) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy && tick) begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
        // a write only lands while idle; busy writes are dropped
        if (wr && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.val  = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign fire_o = fire;
    assign val_o  = s_q.val;
endmodule

// File: rtl/wc_calendar.sv
module wc_calendar
    import wc_pkg::*;
#(
    parameter int COMMIT_TICKS = 2,
    parameter int YEAR_LAST    = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              lin_mode,
    input  logic              wr_time,
    input  logic              wr_date,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] time_o,
    output logic [WORD_W-1:0] date_o,
    output logic [WORD_W-1:0] status_o
);
    localparam int N_REG = 2;   // index 0 time, 1 date

    typedef struct packed {
        logic [WORD_W-1:0] tm;
        logic [WORD_W-1:0] dt;
    } cal_t;

    cal_t st_d, st_q;

    logic [N_REG-1:0]  wr_v, busy_v, fire_v;
    logic [WORD_W-1:0] pend_v [N_REG];
    logic [WORD_W-1:0] tm_next, dt_next;
    logic              day_wrap;

    assign wr_v = {wr_date, wr_time};

    for (genvar g = 0; g < N_REG; g++) begin : g_commit
        wc_commit #(.W(WORD_W), .TICKS(COMMIT_TICKS)) u_commit (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (sec_tick),
            .wr     (wr_v[g]),
            .wdata  (wr_data),
            .busy_o (busy_v[g]),
            .fire_o (fire_v[g]),
            .val_o  (pend_v[g])
        );
    end

    wc_time_step u_time_step (
        .t_i        (st_q.tm),
        .t_o        (tm_next),
        .day_wrap_o (day_wrap)
    );

    wc_date_step #(.YEAR_LAST(YEAR_LAST)) u_date_step (
        .d_i   (st_q.dt),
        .lin_i (lin_mode),
        .d_o   (dt_next)
    );

    always_comb begin
        st_d = st_q;
        if (sec_tick) begin
            st_d.tm = tm_next;
            if (day_wrap) st_d.dt = dt_next;
        end
        // a commit replaces whatever the tick produced
        if (fire_v[0]) st_d.tm = pend_v[0] & TIME_MASK;
        if (fire_v[1]) st_d.dt = pend_v[1] & (lin_mode ? LIN_MASK : CAL_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tm <= '0;
            st_q.dt <= DATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o   = st_q.tm;
    assign date_o   = st_q.dt;
    assign status_o = {22'b0, 1'b0, busy_v[0], busy_v[1], 7'b0};
endmodule

// File: rtl/wc_calendar_chk.sv
module wc_calendar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sec_tick,
    input logic        wr_time,
    input logic        wr_date,
    input logic [31:0] time_o,
    input logic [31:0] status_o
);
    // R6: accepted time write raises busy bit 8
    a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_time && !status_o[8]) |=> status_o[8]);

    // R7: accepted date write raises busy bit 7
    a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_date && !status_o[7]) |=> status_o[7]);

    // R6: a busy bit only drops on a tick
    a_r6_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[8]) |-> $past(sec_tick));

    // R2: without a tick and with no time commit pending, time holds
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !status_o[8]) |=> $stable(time_o));

    // R2: undisturbed tick increments the seconds
    a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !status_o[8] && time_o[5:0] < 6'd59)
        |=> time_o[5:0] == 6'($past(time_o[5:0]) + 6'd1));

    // R3: seconds wrap to zero
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !status_o[8] && time_o[5:0] >= 6'd59) |=> time_o[5:0] == 6'd0);

    // R10: undefined time bits never set
    a_r10_time_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (time_o & ~32'h001F_3F3F) == 32'h0);
endmodule

bind wc_calendar wc_calendar_chk u_chk (.*);

// File: tb/test_wc_calendar.sv
module test_wc_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        lin_mode = 1'b0;
    logic        wr_time = 1'b0;
    logic        wr_date = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] time_o, date_o, status_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [95:0] exp_q [$];
    string       tag_q [$];
    string       cur_tag = "R1";

    // behavioural model state
    logic [31:0] m_time = '0, m_date = 32'h0000_0101;
    logic [31:0] m_pt = '0, m_pd = '0;
    bit          m_bt = 0, m_bd = 0;
    int          m_ct = 0, m_cd = 0;

    always #2 clk = ~clk;   // 250 MHz

    wc_calendar i_wc_calendar (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .lin_mode(lin_mode),
        .wr_time(wr_time), .wr_date(wr_date), .wr_data(wr_data),
        .time_o(time_o), .date_o(date_o), .status_o(status_o)
    );

    function automatic logic [31:0] tpack(int h, int m, int s);
        return {11'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
    endfunction

    function automatic logic [31:0] dpack(bit lp, int y, int mo, int d);
        return {9'b0, lp, 6'(y), 4'b0, 4'(mo), 3'b0, 5'(d)};
    endfunction

    function automatic int mdays(int mo, bit lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // returns {wrap, next time}
    function automatic logic [32:0] tadv(logic [31:0] t);
        int s = int'(t[5:0]);
        int m = int'(t[13:8]);
        int h = int'(t[20:16]);
        bit w = 0;
        s++;
        if (s >= 60) begin s = 0; m++; end
        if (m >= 60) begin m = 0; h++; end
        if (h >= 24) begin h = 0; w = 1; end
        return {w, tpack(h, m, s)};
    endfunction

    function automatic logic [31:0] dadv(logic [31:0] d, bit lin);
        int dy = int'(d[4:0]);
        int mo = int'(d[11:8]);
        int yr = int'(d[21:16]);
        bit lp = d[22];
        if (lin) return {16'b0, 16'(d[15:0] + 16'd1)};
        if (dy < mdays(mo, lp)) return dpack(lp, yr, mo, dy + 1);
        if (mo < 12) return dpack(lp, yr, mo + 1, 1);
        return dpack(lp, (yr >= 63) ? 0 : yr + 1, 1, 1);
    endfunction

    task automatic model(bit tk, bit wt, bit wd, logic [31:0] dat);
        bit ob_t = m_bt;
        bit ob_d = m_bd;
        bit ft = ob_t && tk && (m_ct == 1);
        bit fd = ob_d && tk && (m_cd == 1);
        logic [32:0] tn;
        if (tk) begin
            tn = tadv(m_time);
            m_time = tn[31:0];
            if (tn[32]) m_date = dadv(m_date, lin_mode);
        end
        if (ft) begin m_time = m_pt & 32'h001F_3F3F; m_bt = 0; end
        else if (tk && ob_t) m_ct++;
        if (fd) begin m_date = m_pd & (lin_mode ? 32'h0000_FFFF : 32'h007F_0F1F); m_bd = 0; end
        else if (tk && ob_d) m_cd++;
        if (wt && !ob_t) begin m_pt = dat; m_bt = 1; m_ct = 0; end
        if (wd && !ob_d) begin m_pd = dat; m_bd = 1; m_cd = 0; end
    endtask

    // driver: drive one cycle, push expected post-edge outputs
    task automatic step(bit tk, bit wt, bit wd, logic [31:0] dat);
        logic [31:0] st;
        @(negedge clk);
        sec_tick = tk; wr_time = wt; wr_date = wd; wr_data = dat;
        model(tk, wt, wd, dat);
        st = {22'b0, 1'b0, m_bt, m_bd, 7'b0};   // R9 bit 9 zero
        exp_q.push_back({m_time, m_date, st});
        tag_q.push_back(cur_tag);
    endtask

    task automatic load(logic [31:0] d, logic [31:0] t);
        step(0, 0, 1, d);
        step(0, 1, 0, t);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic midnight_case(string tg, logic [31:0] d);
        cur_tag = tg;
        load(d, tpack(23, 59, 59));
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
    endtask

    // monitor: pop expected items after each edge and compare
    initial begin
        forever begin
            logic [95:0] e;
            string       tg;
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                total++;
                if ({time_o, date_o, status_o} !== e) begin
                    bad++;
                    $display("FAIL %s: time %h exp %h, date %h exp %h, status %h exp %h",
                             tg, time_o, e[95:64], date_o, e[63:32], status_o, e[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_tag = "R1";
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // R2: tick advance and idle hold
        cur_tag = "R2";
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        // R6 and R8: time write, second write while busy dropped
        cur_tag = "R6_R8";
        step(0, 1, 0, tpack(23, 59, 57));
        step(0, 1, 0, tpack(5, 5, 5));
        step(1, 1, 0, tpack(6, 6, 6));
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        // R3: roll through midnight into the date
        cur_tag = "R3";
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        // R7: date write
        cur_tag = "R7";
        step(0, 0, 1, dpack(0, 5, 7, 14));
        step(0, 0, 1, dpack(0, 9, 9, 9));
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        // R4: month lengths, leap bit, year wrap
        midnight_case("R4_feb_noleap", dpack(0, 1, 2, 28));
        midnight_case("R4_feb_leap",   dpack(1, 2, 2, 28));
        midnight_case("R4_feb29",      dpack(1, 2, 2, 29));
        midnight_case("R4_apr30",      dpack(0, 3, 4, 30));
        midnight_case("R4_jan31",      dpack(0, 3, 1, 31));
        midnight_case("R4_year_wrap",  dpack(1, 63, 12, 31));
        // R10: garbage bits masked on commit
        cur_tag = "R10";
        load(32'hFF80_F0E0 | dpack(0, 4, 6, 3), 32'hFFC0_C0C0 | tpack(1, 2, 3));
        step(0, 0, 0, 0);
        // R5: linear day count
        @(negedge clk);
        lin_mode = 1'b1;
        midnight_case("R5_wrap", 32'hABCD_FFFF);
        cur_tag = "R5_step";
        load(32'h0000_0010, tpack(23, 59, 59));
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule